// File: doc/BRIEF.md
# Front-Panel Self-Test Mode Controller

This block sits between a small operator panel (16 push buttons, 8 slide switches, 16 LEDs and four 7-segment digits) and the host logic that normally owns the panel outputs. In normal operation the LEDs and the digits show whatever the host last wrote into two holding registers. The host cannot read these registers back. One host write fills every device behind the selected address in the same cycle.

An operator can put the panel into a self-test mode with a guarded gesture. Switch 1 must be up and switch 8 must be down. While that holds, buttons 0, 7 and 14 are held down together. In self-test the LEDs mirror the buttons. Each digit shows the hex value of its own pair of switches. A fresh press of button 0 ends the test, and it takes effect once button 0 is let go. All inputs arrive already debounced and synchronised.

The mode machine has three states: NORMAL, TEST and EXIT_WAIT. The transitions are:
- **ENTER**: NORMAL to TEST, when the switch precondition and the three-button chord hold together.
- **ARM**: inside TEST, button 0 is seen released.
- **REQUEST**: TEST to EXIT_WAIT, when button 0 is pressed while armed.
- **LEAVE**: EXIT_WAIT to NORMAL, when button 0 is released.

Top module: `panel_selftest_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block is in NORMAL, `test_active_o` is 0, `led_o` is all zero and `seg_o` is all zero.
- R2: In NORMAL, a host write with `host_sel_i`=0 loads `host_wdata_i[15:0]` into the LED register. A write with `host_sel_i`=1 loads all 28 bits into the display register, so all four digits change at once. Both take effect on `led_o`/`seg_o` in the cycle after the write edge.
- R3: In NORMAL, if `sw_i[0]`=1, `sw_i[7]`=0 and `btn_i[0]`, `btn_i[7]` and `btn_i[14]` are all 1 at a clock edge, the block is in TEST after that edge and `test_active_o` is 1. The other buttons and switches do not matter.
- R4: In NORMAL, the block stays in NORMAL when any chord button is missing, when `sw_i[0]`=0, or when `sw_i[7]`=1.
- R5: While `test_active_o` is 1, `led_o` equals `btn_i` in the same cycle.
- R6: While `test_active_o` is 1, digit k (`seg_o[7k+6:7k]`) shows the hex value {2'b00, `sw_i[2k+1:2k]`}. Segments are active high, segment a is at bit 0 and segment g at bit 6. The codes are 0=0x3F, 1=0x06, 2=0x5B and 3=0x4F.
- R7: After ENTER, holding button 0 continuously never leaves test mode. Button 0 must first be seen released (ARM) before a later press counts.
- R8: An armed press of button 0 moves to EXIT_WAIT, where `test_active_o` stays 1 and the test routing remains. The release of button 0 returns the block to NORMAL at the next edge.
- R9: Host writes during TEST or EXIT_WAIT update the holding registers but not the outputs. After returning to NORMAL the outputs show the last values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_i | input | 16 | Debounced button levels, bit n is button n |
| sw_i | input | 8 | Debounced switch levels, bit 0 is switch 1, bit 7 is switch 8 |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | Write target: 0 LED register, 1 display register |
| host_wdata_i | input | 28 | Write data |
| led_o | output | 16 | LED drive, active high |
| seg_o | output | 28 | Four digits of 7 segments, digit k at bits 7k+6..7k |
| test_active_o | output | 1 | 1 in TEST or EXIT_WAIT |

## Verification
The assertions check on every cycle the parts that follow from the current cycle alone:
- the entry decision from NORMAL, both taken and refused;
- that the LEDs and the digits follow the panel while test mode is active;
- that a held button 0 never ends test mode;
- the next-cycle effect of a host write in NORMAL.

Some behaviour depends on history, so only the bench scenarios can show it. This covers the need to release button 0 before an exit counts, and the EXIT_WAIT hold until release. It also covers the host writes made during test mode, which must stay hidden and then appear after the return to NORMAL.

// File: rtl/panel_pkg.sv
package panel_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_TEST      = 2'd1,
        ST_EXIT_WAIT = 2'd2
    } panel_mode_e;

    localparam int SEG_W = 7;

    // Hex nibble to active-high segments, bit 0 = a ... bit 6 = g
    function automatic logic [SEG_W-1:0] hex7_f(input logic [3:0] nib);
        logic [SEG_W-1:0] s;
        case (nib)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/panel_mode_fsm.sv
module panel_mode_fsm
    import panel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        entry_ok_i,
    input  logic        exit_btn_i,
    output panel_mode_e mode_o
);

    panel_mode_e state_q, state_d;
    logic        armed_q, armed_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        armed_d = armed_q;
        unique case (state_q)
            ST_NORMAL: begin
                armed_d = 1'b0;
                if (entry_ok_i) begin
                    state_d = ST_TEST;          // ENTER
                end
            end
            ST_TEST: begin
                if (armed_q && exit_btn_i) begin
                    state_d = ST_EXIT_WAIT;     // REQUEST
                end else if (!exit_btn_i) begin
                    armed_d = 1'b1;             // ARM
                end
            end
            ST_EXIT_WAIT: begin
                armed_d = 1'b0;
                if (!exit_btn_i) begin
                    state_d = ST_NORMAL;        // LEAVE
                end
            end
            default: begin
                state_d = ST_NORMAL;
                armed_d = 1'b0;
            end
        endcase
    end

    assign mode_o = state_q;

endmodule

// File: rtl/panel_host_regs.sv
module panel_host_regs #(
    parameter int LED_W  = 16,
    parameter int DISP_W = 28,
    parameter int HOST_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [HOST_W-1:0] wdata_i,
    output logic [LED_W-1:0]  led_q_o,
    output logic [DISP_W-1:0] disp_q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q_o  <= '0;
            disp_q_o <= '0;
        end else if (we_i) begin
            if (sel_i) begin
                disp_q_o <= wdata_i[DISP_W-1:0];
            end else begin
                led_q_o <= wdata_i[LED_W-1:0];
            end
        end
    end

endmodule

// File: rtl/panel_switch_decode.sv
module panel_switch_decode
    import panel_pkg::*;
#(
    parameter int NUM_DIG = 4,
    parameter int SW_PER_DIG = 2,
    localparam int NUM_SW = NUM_DIG * SW_PER_DIG,
    localparam int DISP_W = NUM_DIG * SEG_W
) (
    input  logic [NUM_SW-1:0] sw_i,
    output logic [DISP_W-1:0] seg_o
);

    for (genvar k = 0; k < NUM_DIG; k++) begin : g_dig
        logic [3:0] nib;
        assign nib = 4'(sw_i[k*SW_PER_DIG +: SW_PER_DIG]);
        assign seg_o[k*SEG_W +: SEG_W] = hex7_f(nib);
    end

endmodule

// File: rtl/panel_selftest_ctrl.sv
module panel_selftest_ctrl
    import panel_pkg::*;
#(
    parameter int NUM_BTN    = 16,
    parameter int NUM_SW     = 8,
    parameter int SW_PER_DIG = 2,
    parameter int EXIT_BTN   = 0,
    parameter int CHORD_B    = 7,
    parameter int CHORD_C    = 14,
    parameter int SW_UP      = 0,
    parameter int SW_DOWN    = 7,
    localparam int NUM_DIG   = NUM_SW / SW_PER_DIG,
    localparam int DISP_W    = NUM_DIG * SEG_W,
    localparam int HOST_W    = (NUM_BTN > DISP_W) ? NUM_BTN : DISP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] btn_i,
    input  logic [NUM_SW-1:0]  sw_i,
    input  logic               host_we_i,
    input  logic               host_sel_i,
    input  logic [HOST_W-1:0]  host_wdata_i,
    output logic [NUM_BTN-1:0] led_o,
    output logic [DISP_W-1:0]  seg_o,
    output logic               test_active_o
);

    panel_mode_e        mode;
    logic               entry_ok;
    logic [NUM_BTN-1:0] host_led;
    logic [DISP_W-1:0]  host_disp;
    logic [DISP_W-1:0]  sw_segs;

    assign entry_ok = sw_i[SW_UP] && !sw_i[SW_DOWN] &&
                      btn_i[EXIT_BTN] && btn_i[CHORD_B] && btn_i[CHORD_C];

    panel_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_ok_i (entry_ok),
        .exit_btn_i (btn_i[EXIT_BTN]),
        .mode_o     (mode)
    );

    panel_host_regs #(
        .LED_W  (NUM_BTN),
        .DISP_W (DISP_W),
        .HOST_W (HOST_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (host_we_i),
        .sel_i    (host_sel_i),
        .wdata_i  (host_wdata_i),
        .led_q_o  (host_led),
        .disp_q_o (host_disp)
    );

    panel_switch_decode #(
        .NUM_DIG    (NUM_DIG),
        .SW_PER_DIG (SW_PER_DIG)
    ) u_dec (
        .sw_i  (sw_i),
        .seg_o (sw_segs)
    );

    // output routing per state
    always_comb begin
        unique case (mode)
            ST_TEST, ST_EXIT_WAIT: begin
                led_o         = btn_i;
                seg_o         = sw_segs;
                test_active_o = 1'b1;
            end
            default: begin
                led_o         = host_led;
                seg_o         = host_disp;
                test_active_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/panel_selftest_chk.sv
module panel_selftest_chk
    import panel_pkg::*;
#(
    parameter int NUM_BTN    = 16,
    parameter int NUM_SW     = 8,
    parameter int SW_PER_DIG = 2,
    parameter int NUM_DIG    = 4,
    parameter int DISP_W     = 28,
    parameter int HOST_W     = 28,
    parameter int EXIT_BTN   = 0,
    parameter int CHORD_B    = 7,
    parameter int CHORD_C    = 14,
    parameter int SW_UP      = 0,
    parameter int SW_DOWN    = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_BTN-1:0] btn_i,
    input logic [NUM_SW-1:0]  sw_i,
    input logic               host_we_i,
    input logic               host_sel_i,
    input logic [HOST_W-1:0]  host_wdata_i,
    input logic [NUM_BTN-1:0] led_o,
    input logic [DISP_W-1:0]  seg_o,
    input logic               test_active_o
);

    logic chord;
    assign chord = sw_i[SW_UP] && !sw_i[SW_DOWN] &&
                   btn_i[EXIT_BTN] && btn_i[CHORD_B] && btn_i[CHORD_C];

    // R3
    enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_active_o && chord) |=> test_active_o);

    // R4
    stay_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_active_o && !chord) |=> !test_active_o);

    // R5
    led_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_active_o |-> (led_o == btn_i));

    // R7
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active_o && btn_i[EXIT_BTN]) |=> test_active_o);

    // R2
    led_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_active_o && !chord && host_we_i && !host_sel_i)
        |=> (led_o == $past(host_wdata_i[NUM_BTN-1:0])));

    // R2
    seg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_active_o && !chord && host_we_i && host_sel_i)
        |=> (seg_o == $past(host_wdata_i[DISP_W-1:0])));

    for (genvar k = 0; k < NUM_DIG; k++) begin : g_seg
        // R6
        seg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            test_active_o |->
            (seg_o[k*SEG_W +: SEG_W] ==
             hex7_f(4'(sw_i[k*SW_PER_DIG +: SW_PER_DIG]))));
    end

endmodule

bind panel_selftest_ctrl panel_selftest_chk #(
    .NUM_BTN    (NUM_BTN),
    .NUM_SW     (NUM_SW),
    .SW_PER_DIG (SW_PER_DIG),
    .NUM_DIG    (NUM_DIG),
    .DISP_W     (DISP_W),
    .HOST_W     (HOST_W),
    .EXIT_BTN   (EXIT_BTN),
    .CHORD_B    (CHORD_B),
    .CHORD_C    (CHORD_C),
    .SW_UP      (SW_UP),
    .SW_DOWN    (SW_DOWN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .btn_i         (btn_i),
    .sw_i          (sw_i),
    .host_we_i     (host_we_i),
    .host_sel_i    (host_sel_i),
    .host_wdata_i  (host_wdata_i),
    .led_o         (led_o),
    .seg_o         (seg_o),
    .test_active_o (test_active_o)
);

// File: tb/panel_selftest_ctrl_test.sv
`timescale 1ns/100ps
module panel_selftest_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] btn = '0;
    logic [7:0]  sw = '0;
    logic        we = 1'b0;
    logic        sel = 1'b0;
    logic [27:0] wd = '0;
    logic [15:0] led_o;
    logic [27:0] seg_o;
    logic        act_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench reference model
    int          m_state = 0;   // 0 normal, 1 test, 2 exit wait
    bit          m_armed = 1'b0;
    logic [15:0] m_led = '0;
    logic [27:0] m_seg = '0;

    always #2.5 clk = ~clk;

    panel_selftest_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .btn_i         (btn),
        .sw_i          (sw),
        .host_we_i     (we),
        .host_sel_i    (sel),
        .host_wdata_i  (wd),
        .led_o         (led_o),
        .seg_o         (seg_o),
        .test_active_o (act_o)
    );

    function automatic logic [6:0] seg_code(input int v);
        case (v)
            0: return 7'h3F;
            1: return 7'h06;
            2: return 7'h5B;
            default: return 7'h4F;
        endcase
    endfunction

    function automatic logic [27:0] exp_segs(input logic [7:0] s);
        logic [27:0] r;
        for (int k = 0; k < 4; k++) r[k*7 +: 7] = seg_code(int'(s[k*2 +: 2]));
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, compare, then advance model at posedge
    task automatic step(input logic [15:0] b, input logic [7:0] s,
                        input logic w, input logic sl, input logic [27:0] d);
        bit ok;
        @(negedge clk);
        btn = b; sw = s; we = w; sel = sl; wd = d;
        #1;
        check("R3 mode", 64'(act_o), 64'(m_state != 0));
        if (m_state != 0) begin
            check("R5 led", 64'(led_o), 64'(b));
            check("R6 seg", 64'(seg_o), 64'(exp_segs(s)));
        end else begin
            check("R2 led", 64'(led_o), 64'(m_led));
            check("R2 seg", 64'(seg_o), 64'(m_seg));
        end
        @(posedge clk);
        ok = s[0] && !s[7] && b[0] && b[7] && b[14];
        if (w) begin
            if (sl) m_seg = d; else m_led = d[15:0];
        end
        case (m_state)
            0: if (ok) begin m_state = 1; m_armed = 1'b0; end
            1: if (m_armed && b[0]) m_state = 2; else if (!b[0]) m_armed = 1'b1;
            default: if (!b[0]) m_state = 0;
        endcase
    endtask

    task automatic check_active(input string tag, input logic exp);
        #1;
        check(tag, 64'(act_o), 64'(exp));
    endtask

    localparam logic [15:0] CHORD = 16'h4081;

    initial begin
        int seed;
        seed = int'($urandom(32'h5EED));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 active", 64'(act_o), 64'd0);
        check("R1 led", 64'(led_o), 64'd0);
        check("R1 seg", 64'(seg_o), 64'd0);
        rst_n = 1'b1;
        step('0, '0, 1'b0, 1'b0, '0);
        check("R1 led after release", 64'(led_o), 64'd0);

        // R2: host writes in normal mode
        step('0, '0, 1'b1, 1'b0, 28'h000A5C3);
        step('0, '0, 1'b1, 1'b1, 28'h3F06_5B4 ^ 28'h1234567);
        step('0, '0, 1'b0, 1'b0, '0);

        // R4: precondition or chord missing
        step(CHORD, 8'h81, 1'b0, 1'b0, '0);
        check_active("R4 sw8 high", 1'b0);
        step(CHORD, 8'h00, 1'b0, 1'b0, '0);
        check_active("R4 sw1 low", 1'b0);
        step(16'h0081, 8'h01, 1'b0, 1'b0, '0);
        check_active("R4 btn14 missing", 1'b0);
        step(16'h4080, 8'h01, 1'b0, 1'b0, '0);
        check_active("R4 btn0 missing", 1'b0);

        // R3: entry with extra buttons and switches
        step(CHORD | 16'h0300, 8'h4D, 1'b0, 1'b0, '0);
        check_active("R3 entry", 1'b1);

        // R7: btn0 held continuously
        for (int i = 0; i < 6; i++) begin
            step(16'h0001 | 16'(i << 4), 8'(i * 37) & 8'h7F, 1'b0, 1'b0, '0);
            check_active("R7 held", 1'b1);
        end
        // R9: writes hidden during test
        step(16'h0001, 8'h1B, 1'b1, 1'b0, 28'h000BEEF);
        step(16'h0001, 8'h1B, 1'b1, 1'b1, 28'h9ABCDEF);
        // ARM then REQUEST (R8)
        step(16'h0000, 8'hE4, 1'b0, 1'b0, '0);
        check_active("R8 armed", 1'b1);
        step(16'h8001, 8'hE4, 1'b0, 1'b0, '0);
        check_active("R8 exit wait", 1'b1);
        step(16'h0001, 8'h27, 1'b0, 1'b0, '0);
        check_active("R8 still held", 1'b1);
        step(16'h0000, 8'h27, 1'b0, 1'b0, '0);
        check_active("R8 leave", 1'b0);
        #1;
        check("R9 led restored", 64'(led_o), 64'h000BEEF);
        check("R9 seg restored", 64'(seg_o), 64'h9ABCDEF);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] b;
            logic [7:0]  s;
            b = 16'($urandom()) & 16'($urandom());
            s = 8'($urandom());
            if (($urandom() % 6) == 0) begin
                b = b | CHORD;
                s = (s | 8'h01) & 8'h7F;
            end
            if (m_state != 0 && ($urandom() % 3) != 0) b[0] = 1'b1;
            step(b, s, 1'($urandom()), 1'($urandom()), 28'($urandom()));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule